// File: doc/BRIEF.md
# Serial Flash Quad-Enable Sequencer

After reset this block runs a short, fixed dialogue over a single-bit SPI link so that an external serial flash has its quad-enable status bit set before any quad-width reads begin. It reads the flash's second status register and compares the byte with the required value. On a match it signals completion at once. On a mismatch it unlocks the flash for writing, writes the second status register with the required value, and then keeps reading the primary status register until the flash reports that it is no longer busy. If the flash stays busy for more polls than a parameter allows, a timeout flag is raised in place of completion.

Each command is framed by its own chip-select low period. Between frames chip select stays high for a parameterised number of serial clock periods. The serial clock is the system clock divided by an even parameter (minimum 2). The link runs in SPI mode 0, so the clock idles low, the block samples on the rising edge and changes data on the falling edge. Every byte is sent most significant bit first. After completion or timeout the block goes idle and holds its result until the next reset.

The controller is one state machine. Its states are: `ST_BOOT_GAP` (chip select high after reset), `ST_RD_OP` / `ST_RD_DAT` (send 0x35, receive the register byte), `ST_RD_GAP`, `ST_WE_OP` (send 0x06 alone), `ST_WE_GAP`, `ST_WR_OP` / `ST_WR_DAT` (send 0x31 and the required value), `ST_WR_GAP`, `ST_PL_OP` / `ST_PL_DAT` (send 0x05, receive status), `ST_PL_GAP`, `ST_DONE` and `ST_FAULT`. Each gap state lasts the configured chip-select gap. Each byte state advances when the byte shifter reports its byte complete. The transitions are: `ST_BOOT_GAP`→`ST_RD_OP`→`ST_RD_DAT`→`ST_RD_GAP`; from `ST_RD_GAP` a match goes to `ST_DONE` and a mismatch goes to `ST_WE_OP`; `ST_WE_OP`→`ST_WE_GAP`→`ST_WR_OP`→`ST_WR_DAT`→`ST_WR_GAP`→`ST_PL_OP`→`ST_PL_DAT`→`ST_PL_GAP`. From `ST_PL_GAP`, a busy response goes back to `ST_PL_OP`, or to `ST_FAULT` once the poll limit is reached. A response that is not busy goes to `ST_DONE`.

Top module: `flash_qe_seq`

## Requirements
- R1: While reset is asserted, and right after it, chip select is high (1), the serial clock is low, and both completion and timeout are low.
- R2: Mode 0 framing. The serial clock is low whenever chip select changes. The output data line changes only while the clock is low. Input data is sampled on the rising edge. Bytes go most significant bit first.
- R3: The first frame after reset carries exactly two bytes: command 0x35, then one byte shifted out as 0x00 during which the flash's response is captured.
- R4: If the captured byte equals the required value (default 0x02), completion is raised. No further frame is issued, and chip select stays high from then on.
- R5: If the captured byte differs from the required value in any bit, the next frame is the single byte 0x06. The frame after it is two bytes: 0x31, then the required value.
- R6: After the write, the block issues two-byte frames that start with 0x05. It repeats them while bit 0 of the captured response is 1 and ignores the other seven bits. A response with bit 0 equal to 0 raises completion.
- R7: Between any two frames, chip select stays high for at least CS_GAP_SCLK × CLK_DIV system clock cycles.
- R8: Each high phase of the serial clock lasts exactly CLK_DIV/2 system clock cycles. Each low phase inside a frame lasts at least CLK_DIV/2 cycles.
- R9: If the first MAX_POLLS poll responses all have bit 0 set, timeout is raised after the last of them and no further frame is issued.
- R10: Completion and timeout are never high together. Once either one rises, it stays high until reset.
- R11: While chip select is high, the serial clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| spi_miso | input | 1 | Serial data from the flash |
| spi_cs_n | output | 1 | Chip select to the flash, active low |
| spi_sclk | output | 1 | Serial clock, system clock divided by CLK_DIV |
| spi_mosi | output | 1 | Serial data to the flash |
| qe_done | output | 1 | Quad-enable confirmed; sticky until reset |
| qe_timeout | output | 1 | Busy poll limit exceeded; sticky until reset |

## Verification
The assertions check the link-level rules on every cycle:
- clock idle low while chip select is high;
- data stable while the clock is high;
- chip select moving only with the clock low;
- the exact high-phase width and the minimum chip-select gap, measured with counters;
- completion and timeout being exclusive, sticky and quiet on the link.

Only the bench's scenarios can show that the frame sequence itself is right. Those scenarios run a flash model with different register values and busy lengths, which exercises:
- the byte values and their order, and the skip on a match;
- the two-frame write;
- the poll count, including the boundary one poll short of the limit versus exactly at it;
- a restart from a reset in the middle of a frame.

// File: rtl/flash_qe_pkg.sv
package flash_qe_pkg;

    // Command bytes, most significant bit sent first
    localparam logic [7:0] OP_READ_SR2  = 8'h35;
    localparam logic [7:0] OP_WRITE_EN  = 8'h06;
    localparam logic [7:0] OP_WRITE_SR2 = 8'h31;
    localparam logic [7:0] OP_READ_SR1  = 8'h05;
    localparam logic [7:0] OP_FILLER    = 8'h00;

    typedef enum logic [3:0] {
        ST_BOOT_GAP,
        ST_RD_OP,
        ST_RD_DAT,
        ST_RD_GAP,
        ST_WE_OP,
        ST_WE_GAP,
        ST_WR_OP,
        ST_WR_DAT,
        ST_WR_GAP,
        ST_PL_OP,
        ST_PL_DAT,
        ST_PL_GAP,
        ST_DONE,
        ST_FAULT
    } qe_state_t;

endpackage

// File: rtl/qe_sclk_gen.sv
// Serial clock divider: runs only while a byte is in flight, idles low.
module qe_sclk_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic rise,
    output logic fall
);
    localparam int HALF = DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] phase_cnt;
    logic          level;
    logic          tick;

    assign tick = run && (phase_cnt == CW'(HALF - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_cnt <= '0;
            level     <= 1'b0;
        end else if (!run) begin
            phase_cnt <= '0;
            level     <= 1'b0;
        end else if (tick) begin
            phase_cnt <= '0;
            level     <= ~level;
        end else begin
            phase_cnt <= phase_cnt + 1'b1;
        end
    end

    assign sclk = level;
    assign rise = tick & ~level;
    assign fall = tick & level;

endmodule

// File: rtl/qe_byte_shifter.sv
// One byte in each direction, mode 0: capture on rise, advance on fall.
module qe_byte_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] tx,
    input  logic         miso,
    input  logic         rise,
    input  logic         fall,
    output logic         mosi,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] rx
);
    localparam int BW = (W > 1) ? $clog2(W) : 1;

    logic [W-1:0]  out_sh;
    logic [W-1:0]  in_sh;
    logic [BW-1:0] bit_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_sh  <= '0;
            in_sh   <= '0;
            bit_idx <= '0;
            busy    <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                out_sh  <= tx;
                bit_idx <= '0;
                busy    <= 1'b1;
            end else if (busy) begin
                if (rise) begin
                    in_sh <= {in_sh[W-2:0], miso};
                end
                if (fall) begin
                    if (bit_idx == BW'(W - 1)) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        bit_idx <= bit_idx + 1'b1;
                        out_sh  <= {out_sh[W-2:0], 1'b0};
                    end
                end
            end
        end
    end

    assign mosi = out_sh[W-1];
    assign rx   = in_sh;

endmodule

// File: rtl/qe_poll_limit.sv
// Counts status polls and flags when the allowed number is used up.
module qe_poll_limit #(
    parameter int MAX = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic bump,
    output logic limit_hit
);
    localparam int CW = $clog2(MAX + 1);

    logic [CW-1:0] polls;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            polls <= '0;
        end else if (clear) begin
            polls <= '0;
        end else if (bump && (polls != CW'(MAX))) begin
            polls <= polls + 1'b1;
        end
    end

    assign limit_hit = (polls == CW'(MAX));

endmodule

// File: rtl/flash_qe_seq.sv
module flash_qe_seq
    import flash_qe_pkg::*;
#(
    parameter int         CLK_DIV     = 4,
    parameter int         CS_GAP_SCLK = 1,
    parameter int         MAX_POLLS   = 100000,
    parameter logic [7:0] QE_VALUE    = 8'h02,
    parameter int         BUSY_BIT    = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_miso,
    output logic spi_cs_n,
    output logic spi_sclk,
    output logic spi_mosi,
    output logic qe_done,
    output logic qe_timeout
);
    localparam int BYTE_W  = 8;
    localparam int GAP_LEN = CS_GAP_SCLK * CLK_DIV;
    localparam int GAP_W   = $clog2(GAP_LEN + 1);

    qe_state_t          state;
    qe_state_t          nxt;
    logic [GAP_W-1:0]   gap_cnt;
    logic               in_gap;
    logic               in_xfer;
    logic               gap_end;
    logic               xfer_go;
    logic [BYTE_W-1:0]  tx_byte;
    logic [BYTE_W-1:0]  resp_q;
    logic               sh_busy;
    logic               sh_done;
    logic [BYTE_W-1:0]  sh_rx;
    logic               clk_rise;
    logic               clk_fall;
    logic               poll_bump;
    logic               poll_clear;
    logic               poll_limit;

    // ---------------- sub-blocks ----------------
    qe_sclk_gen #(.DIV(CLK_DIV)) u_sclk (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (sh_busy),
        .sclk  (spi_sclk),
        .rise  (clk_rise),
        .fall  (clk_fall)
    );

    qe_byte_shifter #(.W(BYTE_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .start (xfer_go),
        .tx    (tx_byte),
        .miso  (spi_miso),
        .rise  (clk_rise),
        .fall  (clk_fall),
        .mosi  (spi_mosi),
        .busy  (sh_busy),
        .done  (sh_done),
        .rx    (sh_rx)
    );

    assign poll_bump  = (state == ST_PL_DAT) && sh_done;
    assign poll_clear = (state == ST_BOOT_GAP);

    qe_poll_limit #(.MAX(MAX_POLLS)) u_polls (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (poll_clear),
        .bump      (poll_bump),
        .limit_hit (poll_limit)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_BOOT_GAP;
        end else begin
            state <= nxt;
        end
    end

    // chip-select gap timer
    assign gap_end = in_gap && (gap_cnt == GAP_W'(GAP_LEN - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_cnt <= '0;
        end else if (in_gap && !gap_end) begin
            gap_cnt <= gap_cnt + 1'b1;
        end else begin
            gap_cnt <= '0;
        end
    end

    // captured response byte of read frames
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_q <= '0;
        end else if (sh_done && ((state == ST_RD_DAT) || (state == ST_PL_DAT))) begin
            resp_q <= sh_rx;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        nxt = state;
        unique case (state)
            ST_BOOT_GAP: if (gap_end) nxt = ST_RD_OP;
            ST_RD_OP:    if (sh_done) nxt = ST_RD_DAT;
            ST_RD_DAT:   if (sh_done) nxt = ST_RD_GAP;
            ST_RD_GAP: begin
                if (gap_end) begin
                    nxt = (resp_q == QE_VALUE) ? ST_DONE : ST_WE_OP;
                end
            end
            ST_WE_OP:    if (sh_done) nxt = ST_WE_GAP;
            ST_WE_GAP:   if (gap_end) nxt = ST_WR_OP;
            ST_WR_OP:    if (sh_done) nxt = ST_WR_DAT;
            ST_WR_DAT:   if (sh_done) nxt = ST_WR_GAP;
            ST_WR_GAP:   if (gap_end) nxt = ST_PL_OP;
            ST_PL_OP:    if (sh_done) nxt = ST_PL_DAT;
            ST_PL_DAT:   if (sh_done) nxt = ST_PL_GAP;
            ST_PL_GAP: begin
                if (gap_end) begin
                    if (!resp_q[BUSY_BIT]) begin
                        nxt = ST_DONE;
                    end else if (poll_limit) begin
                        nxt = ST_FAULT;
                    end else begin
                        nxt = ST_PL_OP;
                    end
                end
            end
            ST_DONE:     nxt = ST_DONE;
            ST_FAULT:    nxt = ST_FAULT;
            default:     nxt = ST_BOOT_GAP;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        in_gap     = 1'b0;
        in_xfer    = 1'b0;
        tx_byte    = OP_FILLER;
        qe_done    = 1'b0;
        qe_timeout = 1'b0;
        unique case (state)
            ST_BOOT_GAP, ST_RD_GAP, ST_WE_GAP, ST_WR_GAP, ST_PL_GAP: begin
                in_gap = 1'b1;
            end
            ST_RD_OP: begin
                in_xfer = 1'b1;
                tx_byte = OP_READ_SR2;
            end
            ST_WE_OP: begin
                in_xfer = 1'b1;
                tx_byte = OP_WRITE_EN;
            end
            ST_WR_OP: begin
                in_xfer = 1'b1;
                tx_byte = OP_WRITE_SR2;
            end
            ST_WR_DAT: begin
                in_xfer = 1'b1;
                tx_byte = QE_VALUE;
            end
            ST_PL_OP: begin
                in_xfer = 1'b1;
                tx_byte = OP_READ_SR1;
            end
            ST_RD_DAT, ST_PL_DAT: begin
                in_xfer = 1'b1;
            end
            ST_DONE:  qe_done    = 1'b1;
            ST_FAULT: qe_timeout = 1'b1;
            default: ;
        endcase
    end

    assign spi_cs_n = ~in_xfer;
    assign xfer_go  = in_xfer && !sh_busy && !sh_done;

endmodule

// File: rtl/flash_qe_seq_chk.sv
module flash_qe_seq_chk #(
    parameter int CLK_DIV = 4,
    parameter int GAP_LEN = 4
) (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sclk,
    input logic mosi,
    input logic done,
    input logic timeout
);
    localparam int HALF = CLK_DIV / 2;

    logic [15:0] hi_len;
    logic [15:0] cs_hi_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_len    <= '0;
            cs_hi_len <= '0;
        end else begin
            hi_len    <= sclk ? ((hi_len == 16'hFFFF) ? hi_len : hi_len + 1'b1) : '0;
            cs_hi_len <= cs_n ? ((cs_hi_len == 16'hFFFF) ? cs_hi_len : cs_hi_len + 1'b1) : '0;
        end
    end

    // R11
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    // R2
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && sclk) |-> $stable(mosi));

    // R2
    cs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cs_n) || $rose(cs_n)) |-> !sclk);

    // R8
    sclk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> (hi_len == 16'(HALF)));

    // R7
    cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (cs_hi_len >= 16'(GAP_LEN)));

    // R10
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && timeout));

    // R10
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    // R10
    timeout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> timeout);

    // R4
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cs_n);

    // R9
    timeout_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> cs_n);

endmodule

bind flash_qe_seq flash_qe_seq_chk #(
    .CLK_DIV (CLK_DIV),
    .GAP_LEN (CS_GAP_SCLK * CLK_DIV)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (spi_cs_n),
    .sclk    (spi_sclk),
    .mosi    (spi_mosi),
    .done    (qe_done),
    .timeout (qe_timeout)
);

// File: tb/test_flash_qe_seq.sv
module test_flash_qe_seq;
    localparam int CLK_DIV   = 4;
    localparam int MAX_POLLS = 6;
    localparam int NV        = 7;
    localparam int MAXF      = 32;

    // [31:24] register value held by the flash, [23:16] busy responses,
    // [15:8] expected timeout, [7:0] expected frame count
    localparam logic [31:0] VEC [NV] = '{
        {8'h02, 8'd0, 8'd0, 8'd1},
        {8'h00, 8'd0, 8'd0, 8'd4},
        {8'h00, 8'd3, 8'd0, 8'd7},
        {8'h42, 8'd1, 8'd0, 8'd5},
        {8'h03, 8'd0, 8'd0, 8'd4},
        {8'h00, 8'd5, 8'd0, 8'd9},
        {8'h00, 8'd6, 8'd1, 8'd9}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic miso = 1'b0;
    logic cs_n, sclk, mosi, done, timeout;

    always #4 clk = ~clk;

    flash_qe_seq #(
        .CLK_DIV     (CLK_DIV),
        .CS_GAP_SCLK (1),
        .MAX_POLLS   (MAX_POLLS),
        .QE_VALUE    (8'h02),
        .BUSY_BIT    (0)
    ) i_flash_qe_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .spi_miso   (miso),
        .spi_cs_n   (cs_n),
        .spi_sclk   (sclk),
        .spi_mosi   (mosi),
        .qe_done    (done),
        .qe_timeout (timeout)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // ---------------- flash model ----------------
    logic [7:0] sr2_reg;
    int         busy_left;
    logic [7:0] in_sh;
    int         bit_n;
    logic [7:0] cur_b0, cur_b1, resp;
    int         n_frames;
    int         fl_len [MAXF];
    logic [7:0] fl_b0 [MAXF];
    logic [7:0] fl_b1 [MAXF];

    always @(negedge cs_n) begin
        bit_n = 0;
        miso  = 1'b0;
    end

    always @(posedge sclk) begin
        if (!cs_n) begin
            in_sh = {in_sh[6:0], mosi};
            bit_n++;
            if (bit_n == 8) begin
                cur_b0 = in_sh;
                if (in_sh == 8'h35)      resp = sr2_reg;
                else if (in_sh == 8'h05) resp = (busy_left > 0) ? 8'h01 : 8'hFE;
                else                     resp = 8'h00;
            end
            if (bit_n == 16) cur_b1 = in_sh;
        end
    end

    always @(negedge sclk) begin
        if (!cs_n && bit_n >= 8 && bit_n < 16) miso = resp[15 - bit_n];
    end

    always @(posedge cs_n) begin
        if (n_frames < MAXF) begin
            fl_len[n_frames] = bit_n / 8;
            fl_b0[n_frames]  = cur_b0;
            fl_b1[n_frames]  = cur_b1;
        end
        n_frames++;
        if (bit_n == 16 && cur_b0 == 8'h31) sr2_reg = cur_b1;
        if (bit_n == 16 && cur_b0 == 8'h05 && busy_left > 0) busy_left--;
    end

    // ---------------- timing monitor ----------------
    int hi_run = 0, cs_hi_run = 0, min_gap = 1000000, bad_hi = 0, idle_bad = 0;
    bit frame_seen = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (sclk) hi_run++;
            else begin
                if (hi_run != 0 && hi_run != CLK_DIV / 2) bad_hi++;
                hi_run = 0;
            end
            if (cs_n) begin
                cs_hi_run++;
                if (sclk) idle_bad++;
            end else begin
                if (frame_seen && cs_hi_run > 0 && cs_hi_run < min_gap) min_gap = cs_hi_run;
                if (cs_hi_run > 0) frame_seen = 1'b1;
                cs_hi_run = 0;
            end
        end else begin
            hi_run     = 0;
            cs_hi_run  = 0;
            frame_seen = 1'b0;
        end
    end

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    task automatic wait_end();
        int guard = 0;
        while (!(done || timeout) && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic run_vec(input int k);
        logic [31:0] v;
        int exp_fr;
        v = VEC[k];
        exp_fr = int'(v[7:0]);
        rst_n = 1'b0;
        sr2_reg = v[31:24];
        busy_left = int'(v[23:16]);
        repeat (3) @(negedge clk);
        n_frames = 0;
        rst_n = 1'b1;
        wait_end();
        chk(done == !v[8], "R4 R6 done flag", done, !v[8]);
        chk(timeout == v[8], "R9 timeout flag", timeout, v[8]);
        chk(n_frames == exp_fr, "R5 R6 R9 frame count", n_frames, exp_fr);
        chk(fl_len[0] == 2 && fl_b0[0] == 8'h35, "R2 R3 read frame", fl_b0[0], 8'h35);
        if (exp_fr > 1) begin
            chk(fl_len[1] == 1 && fl_b0[1] == 8'h06, "R5 write-enable frame", fl_b0[1], 8'h06);
            chk(fl_len[2] == 2 && fl_b0[2] == 8'h31, "R5 write command", fl_b0[2], 8'h31);
            chk(fl_b1[2] == 8'h02, "R5 write data", fl_b1[2], 8'h02);
            for (int f = 3; f < exp_fr && f < MAXF; f++) begin
                chk(fl_len[f] == 2 && fl_b0[f] == 8'h05, "R6 poll frame", fl_b0[f], 8'h05);
            end
        end
        repeat (60) @(negedge clk);
        chk(n_frames == exp_fr, "R4 R9 no frame after end", n_frames, exp_fr);
        chk(cs_n == 1'b1, "R4 R9 cs idle after end", cs_n, 1);
        chk(done == !v[8] && timeout == v[8], "R10 flags sticky", {done, timeout}, {!v[8], v[8]});
    endtask

    initial begin
        n_frames  = 0;
        sr2_reg   = 8'h02;
        busy_left = 0;
        repeat (2) @(negedge clk);
        // R1 reset state
        chk(cs_n == 1'b1, "R1 cs_n in reset", cs_n, 1);
        chk(sclk == 1'b0, "R1 sclk in reset", sclk, 0);
        chk(done == 1'b0 && timeout == 1'b0, "R1 flags in reset", {done, timeout}, 0);

        for (int k = 0; k < NV; k++) run_vec(k);

        // reset in the middle of a frame, then a clean restart
        rst_n = 1'b0;
        sr2_reg = 8'h00;
        busy_left = 3;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (40) @(negedge clk);
        chk(cs_n == 1'b0, "R3 frame under way", cs_n, 0);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(cs_n == 1'b1 && sclk == 1'b0, "R1 reset mid-frame", {cs_n, sclk}, 2);
        chk(done == 1'b0 && timeout == 1'b0, "R1 flags cleared", {done, timeout}, 0);
        sr2_reg = 8'h02;
        busy_left = 0;
        n_frames = 0;
        rst_n = 1'b1;
        wait_end();
        chk(done == 1'b1 && n_frames == 1, "R4 restart after reset", n_frames, 1);
        chk(fl_b0[0] == 8'h35, "R3 restart frame", fl_b0[0], 8'h35);

        // link timing over all runs
        chk(bad_hi == 0, "R8 sclk high width", bad_hi, 0);
        chk(min_gap >= CLK_DIV && min_gap < 1000000, "R7 cs gap", min_gap, CLK_DIV);
        chk(idle_bad == 0, "R11 sclk idle with cs high", idle_bad, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule